// File: doc/BRIEF.md
# Four-Channel Successive-Approximation Scan Controller

This block is the digital half of a four-channel successive-approximation converter. It makes a slower reference tick from the system clock and runs each channel through three phases: a settle phase, a sample-and-hold phase and a ten-step binary search. In the search it drives a trial code to a DAC port and reads back one comparator bit per step. Each finished 10-bit code goes into that channel's result buffer. The buffers are read through a registered read port.

Software picks a channel set: one channel alone, or channel 0 up to channel N in ascending order. The set runs once or repeats. A conversion is started by a software pulse, by a timer underflow pulse, or by a falling edge on an external pin. A one-cycle interrupt pulse marks the end of each single conversion or full scan. The comparator, the DAC and the reference voltage are outside the block and appear only as ports.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After a synchronous reset, `busy`, `irq` and `sample_hold` are 0 and `dac_code` is 0.
- R2: Each conversion is a 10-bit MSB-first binary search. `cmp_in`=1 means the analog input is at or above the trial code on `dac_code`, and the bit is kept. The stored code equals the analog level in steps of 1/1024 of the reference, and the endpoints 0 and 1023 are included.
- R3: The reference tick period is 2, 4, 8 or 16 clocks for `cfg_div` = 0, 1, 2, 3. One channel takes 12+S ticks, and channels in a scan follow each other with no gap. With a software start, `irq` is high in the cycle that follows clock edge nch*(12+S)*D, counting the edge that accepted the start as edge 0.
- R4: `sample_hold` is high for S ticks per channel, with S=2 when `cfg_long_smp`=0 and S=4 when it is 1. The sampling follows a one-tick settle phase.
- R5: `cfg_chsel` codes 0 to 3 convert only that channel. Codes 4, 5 and 6 convert channels 0 to 1, 0 to 2 and 0 to 3 in ascending order, and code 7 acts as code 6. Buffers of channels outside the set keep their contents.
- R6: With `cfg_cont`=1, the set restarts at its first channel right after its last channel. `irq` pulses once per completed set, and `busy` stays high.
- R7: If `enable` is low when a channel finishes, that channel's result is stored and the sequence stops. `irq` pulses only if that channel was the last one of the set.
- R8: `cfg_src` selects the start source: 0 for `sw_start`, 1 for `tmr_uflow`, 2 for a falling edge of `ext_trig_n`, and 3 for none. Unselected sources are ignored.
- R9: `ext_trig_n` passes through two synchronizing flops before edge detection. A falling edge on the pin is accepted at the third clock edge after the pin changes. A rising edge never starts a conversion.
- R10: A start request is ignored while `busy` is high or while `enable` is low.
- R11: `irq` lasts exactly one clock cycle, and the new result can already be read when it is high.
- R12: The read port is registered: `rd_data` shows the buffer selected by `rd_ch` one clock later. If a store hits the same buffer at the same edge, that read returns the old value.
- R13: `busy` rises at the edge that accepts a start. In one-time mode it falls at the edge that stores the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Converter enable; clearing it stops at the end of the current channel |
| cfg_div | input | 2 | Reference tick divider select (2, 4, 8, 16) |
| cfg_long_smp | input | 1 | Sample length: 0 gives 2 ticks, 1 gives 4 ticks |
| cfg_chsel | input | 3 | Channel set code |
| cfg_cont | input | 1 | 1 repeats the set, 0 runs it once |
| cfg_src | input | 2 | Start source select |
| sw_start | input | 1 | Software start pulse |
| tmr_uflow | input | 1 | Timer underflow pulse |
| ext_trig_n | input | 1 | Asynchronous external trigger, active on its falling edge |
| cmp_in | input | 1 | Comparator result for the current trial code |
| dac_code | output | 10 | Trial code for the DAC |
| conv_ch | output | 2 | Channel currently routed to the sample-and-hold |
| sample_hold | output | 1 | High while the input is being sampled |
| rd_ch | input | 2 | Result buffer read select |
| rd_data | output | 10 | Registered result buffer read data |
| busy | output | 1 | A sequence is in progress |
| irq | output | 1 | One-cycle completion pulse |

## Verification
Two functions of this block can fall on the same clock edge: the store of a finished code into a channel's buffer, and a read of that same buffer. The bench works out the exact store edge of a channel 2 conversion from the R3 latency formula. It holds `rd_ch` at 2 across that edge. The read taken at the store edge must return the previous code, while `irq` is already high. The read at the next edge must return the new code. The bench also sends a second start pulse in the middle of a conversion and checks that the completion time does not move.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_SAMPLE,
    PH_CONV,
    PH_STORE
  } phase_t;

  typedef enum logic [1:0] {
    SRC_SW   = 2'd0,
    SRC_TMR  = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_NONE = 2'd3
  } start_src_t;

endpackage

// File: rtl/adc_ref_div.sv
module adc_ref_div #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  localparam int CNT_W = 2 ** DIV_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // divisor is 2^(div_sel+1); the counter wraps at divisor-1
  assign lim  = CNT_W'((32'd2 << div_sel) - 32'd1);
  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == lim) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_start_sel.sv
module adc_start_sel #(
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] src,
  input  logic       sw_start,
  input  logic       tmr_uflow,
  input  logic       ext_trig_n,
  output logic       start_req
);
  import adc_seq_pkg::*;

  // SYNC_N synchronizing stages plus one history stage for edge detection
  logic [SYNC_N:0] sync_q;
  logic            ext_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_N-1:0], ext_trig_n};
    end
  end

  assign ext_fall = sync_q[SYNC_N] & ~sync_q[SYNC_N-1];

  always_comb begin
    unique case (start_src_t'(src))
      SRC_SW:  start_req = sw_start;
      SRC_TMR: start_req = tmr_uflow;
      SRC_EXT: start_req = ext_fall;
      default: start_req = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_result_buf.sv
module adc_result_buf #(
  parameter int DEPTH = 4,
  parameter int DW    = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] mem [DEPTH];

  // read-first single-clock buffer
  always_ff @(posedge clk) begin
    if (we) begin
      mem[wa] <= wd;
    end
    rd <= mem[ra];
  end
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm #(
  parameter int NUM_CH    = 4,
  parameter int RES_W     = 10,
  parameter int DIV_W     = 2,
  parameter int SMP_SHORT = 2,
  parameter int SMP_LONG  = 4,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int SEL_W    = CH_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic             enable,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_long_smp,
  input  logic [SEL_W-1:0] cfg_chsel,
  input  logic             cfg_cont,
  input  logic             tick,
  input  logic             cmp_in,
  output logic             div_clr,
  output logic             run,
  output logic [DIV_W-1:0] div_sel,
  output logic [CH_W-1:0]  conv_ch,
  output logic [RES_W-1:0] dac_code,
  output logic             sample_hold,
  output logic             wr_en,
  output logic [CH_W-1:0]  wr_addr,
  output logic [RES_W-1:0] wr_data,
  output logic             irq,
  output logic             busy
);
  import adc_seq_pkg::*;

  localparam int BIT_W = $clog2(RES_W);
  localparam int SMP_W = $clog2(SMP_LONG);

  phase_t           ph_q;
  logic [CH_W-1:0]  ch_q, first_q, last_q;
  logic [CH_W-1:0]  first_c, last_c;
  logic [RES_W-1:0] sar_q;
  logic [BIT_W-1:0] bit_q;
  logic [SMP_W-1:0] smp_q, smp_last;
  logic             cont_q, long_q, busy_q, irq_q;
  logic [DIV_W-1:0] div_q;
  logic             accept, at_last;
  int               span;

  // decode the channel set code into first and last channel
  always_comb begin
    span = int'(cfg_chsel) - NUM_CH + 1;
    if (span > NUM_CH - 1) begin
      span = NUM_CH - 1;
    end
    if (int'(cfg_chsel) < NUM_CH) begin
      first_c = cfg_chsel[CH_W-1:0];
      last_c  = cfg_chsel[CH_W-1:0];
    end else begin
      first_c = '0;
      last_c  = CH_W'(span);
    end
  end

  assign accept   = (ph_q == PH_IDLE) && enable && start_req;
  assign at_last  = (ch_q == last_q);
  assign smp_last = long_q ? SMP_W'(SMP_LONG - 1) : SMP_W'(SMP_SHORT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      ch_q    <= '0;
      first_q <= '0;
      last_q  <= '0;
      sar_q   <= '0;
      bit_q   <= '0;
      smp_q   <= '0;
      cont_q  <= 1'b0;
      long_q  <= 1'b0;
      div_q   <= '0;
      busy_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (accept) begin
            first_q <= first_c;
            last_q  <= last_c;
            ch_q    <= first_c;
            cont_q  <= cfg_cont;
            long_q  <= cfg_long_smp;
            div_q   <= cfg_div;
            busy_q  <= 1'b1;
            ph_q    <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (tick) begin
            smp_q <= '0;
            sar_q <= '0;
            ph_q  <= PH_SAMPLE;
          end
        end
        PH_SAMPLE: begin
          if (tick) begin
            if (smp_q == smp_last) begin
              bit_q <= BIT_W'(RES_W - 1);
              ph_q  <= PH_CONV;
            end else begin
              smp_q <= smp_q + 1'b1;
            end
          end
        end
        PH_CONV: begin
          if (tick) begin
            sar_q[bit_q] <= cmp_in;
            if (bit_q == '0) begin
              ph_q <= PH_STORE;
            end else begin
              bit_q <= bit_q - 1'b1;
            end
          end
        end
        PH_STORE: begin
          if (tick) begin
            if (at_last) begin
              irq_q <= 1'b1;
            end
            if (!enable || (at_last && !cont_q)) begin
              busy_q <= 1'b0;
              ph_q   <= PH_IDLE;
            end else begin
              ch_q <= at_last ? first_q : ch_q + 1'b1;
              ph_q <= PH_SETUP;
            end
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign div_clr     = accept;
  assign run         = busy_q;
  assign div_sel     = div_q;
  assign conv_ch     = ch_q;
  assign sample_hold = (ph_q == PH_SAMPLE);
  assign dac_code    = (ph_q == PH_CONV) ? (sar_q | (RES_W'(1) << bit_q)) : sar_q;
  assign wr_en       = (ph_q == PH_STORE) && tick;
  assign wr_addr     = ch_q;
  assign wr_data     = sar_q;
  assign irq         = irq_q;
  assign busy        = busy_q;
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int NUM_CH    = 4,
  parameter int RES_W     = 10,
  parameter int DIV_W     = 2,
  parameter int SMP_SHORT = 2,
  parameter int SMP_LONG  = 4,
  parameter int SYNC_N    = 2,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int SEL_W    = CH_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_long_smp,
  input  logic [SEL_W-1:0] cfg_chsel,
  input  logic             cfg_cont,
  input  logic [1:0]       cfg_src,
  input  logic             sw_start,
  input  logic             tmr_uflow,
  input  logic             ext_trig_n,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic [CH_W-1:0]  conv_ch,
  output logic             sample_hold,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [RES_W-1:0] rd_data,
  output logic             busy,
  output logic             irq
);
  logic             start_req, div_clr, run, tick, wr_en;
  logic [DIV_W-1:0] div_sel;
  logic [CH_W-1:0]  wr_addr;
  logic [RES_W-1:0] wr_data;

  adc_start_sel #(.SYNC_N(SYNC_N)) u_start (
    .clk       (clk),
    .rst       (rst),
    .src       (cfg_src),
    .sw_start  (sw_start),
    .tmr_uflow (tmr_uflow),
    .ext_trig_n(ext_trig_n),
    .start_req (start_req)
  );

  adc_ref_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .clr    (div_clr),
    .run    (run),
    .div_sel(div_sel),
    .tick   (tick)
  );

  adc_scan_fsm #(
    .NUM_CH   (NUM_CH),
    .RES_W    (RES_W),
    .DIV_W    (DIV_W),
    .SMP_SHORT(SMP_SHORT),
    .SMP_LONG (SMP_LONG)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_req   (start_req),
    .enable      (enable),
    .cfg_div     (cfg_div),
    .cfg_long_smp(cfg_long_smp),
    .cfg_chsel   (cfg_chsel),
    .cfg_cont    (cfg_cont),
    .tick        (tick),
    .cmp_in      (cmp_in),
    .div_clr     (div_clr),
    .run         (run),
    .div_sel     (div_sel),
    .conv_ch     (conv_ch),
    .dac_code    (dac_code),
    .sample_hold (sample_hold),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .irq         (irq),
    .busy        (busy)
  );

  adc_result_buf #(.DEPTH(NUM_CH), .DW(RES_W)) u_buf (
    .clk(clk),
    .we (wr_en),
    .wa (wr_addr),
    .wd (wr_data),
    .ra (rd_ch),
    .rd (rd_data)
  );
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
  parameter int CH_W  = 2,
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             busy,
  input logic             irq,
  input logic             sample_hold,
  input logic [CH_W-1:0]  conv_ch,
  input logic [RES_W-1:0] dac_code
);
  // R11: completion pulse lasts a single cycle
  a_r11_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R13: a completion pulse follows a cycle in which the sequence was busy
  a_r13_busy_before_irq: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(busy));

  // R4: sampling only happens inside a busy sequence
  a_r4_sh_needs_busy: assert property (@(posedge clk) disable iff (rst)
    sample_hold |-> busy);

  // R10: a sequence only begins while the converter is enabled
  a_r10_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(enable));

  // R2: trial code is frozen while idle
  a_r2_dac_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (busy || $stable(dac_code)));

  // R5: the routed channel does not move during sampling
  a_r5_ch_stable_sampling: assert property (@(posedge clk) disable iff (rst)
    (sample_hold && $past(sample_hold)) |-> $stable(conv_ch));
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(.CH_W(CH_W), .RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .busy       (busy),
  .irq        (irq),
  .sample_hold(sample_hold),
  .conv_ch    (conv_ch),
  .dac_code   (dac_code)
);

// File: tb/adc_scan_ctrl_tb_top.sv
module adc_scan_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b1;
  logic [1:0] cfg_div = '0;
  logic       cfg_long_smp = 1'b0;
  logic [2:0] cfg_chsel = '0;
  logic       cfg_cont = 1'b0;
  logic [1:0] cfg_src = '0;
  logic       sw_start = 1'b0;
  logic       tmr_uflow = 1'b0;
  logic       ext_trig_n = 1'b1;
  logic       cmp_in;
  logic [9:0] dac_code;
  logic [1:0] conv_ch;
  logic       sample_hold;
  logic [1:0] rd_ch = '0;
  logic [9:0] rd_data;
  logic       busy;
  logic       irq;

  logic [9:0] vin [4];
  int n_chk = 0;
  int n_bad = 0;
  int exp_buf [4];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // analog model: input at or above the trial code gives 1
  assign cmp_in = (vin[conv_ch] >= dac_code);

  adc_scan_ctrl dut_i (
    .clk(clk), .rst(rst), .enable(enable), .cfg_div(cfg_div),
    .cfg_long_smp(cfg_long_smp), .cfg_chsel(cfg_chsel), .cfg_cont(cfg_cont),
    .cfg_src(cfg_src), .sw_start(sw_start), .tmr_uflow(tmr_uflow),
    .ext_trig_n(ext_trig_n), .cmp_in(cmp_in), .dac_code(dac_code),
    .conv_ch(conv_ch), .sample_hold(sample_hold), .rd_ch(rd_ch),
    .rd_data(rd_data), .busy(busy), .irq(irq)
  );

  // {chsel[2:0], div[1:0], long_smp}
  localparam logic [5:0] TBL [10] = '{
    {3'd6, 2'd0, 1'b0}, {3'd0, 2'd1, 1'b1}, {3'd1, 2'd0, 1'b0},
    {3'd2, 2'd2, 1'b0}, {3'd3, 2'd3, 1'b1}, {3'd4, 2'd0, 1'b1},
    {3'd5, 2'd1, 1'b0}, {3'd7, 2'd0, 1'b0}, {3'd6, 2'd0, 1'b1},
    {3'd6, 2'd1, 1'b0}
  };

  function automatic logic [9:0] level(input int r, input int c);
    if (r == 8) return 10'd0;
    if (r == 9) return 10'd1023;
    return 10'((r * 389 + c * 211 + 77) % 1024);
  endfunction

  function automatic int set_first(input int cs);
    return (cs < 4) ? cs : 0;
  endfunction

  function automatic int set_last(input int cs);
    if (cs < 4) return cs;
    return (cs - 3 > 3) ? 3 : cs - 3;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd_buf(input int c, output int v);
    @(negedge clk) rd_ch = 2'(c);
    @(posedge clk);
    @(negedge clk) v = int'(rd_data);
  endtask

  // kind: 0 software, 1 timer, 2 external falling edge
  task automatic run_conv(input int kind, input int extra_at, output int lat, output int sh);
    @(negedge clk);
    case (kind)
      0: sw_start = 1'b1;
      1: tmr_uflow = 1'b1;
      default: ext_trig_n = 1'b0;
    endcase
    @(posedge clk);
    @(negedge clk);
    sw_start = 1'b0;
    tmr_uflow = 1'b0;
    lat = 0;
    sh = 0;
    while (lat < 5000) begin
      sw_start = (lat == extra_at);
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (sample_hold) sh++;
      if (irq) break;
    end
    sw_start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lat, sh, v, d, s, nch, cnt, lowcnt, irqs;
    for (int c = 0; c < 4; c++) vin[c] = 10'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sample_hold", sample_hold, 0);
    chk("R1 dac_code", dac_code, 0);

    // table of modes, dividers and sample lengths
    for (int r = 0; r < 10; r++) begin
      @(negedge clk);
      cfg_chsel = TBL[r][5:3];
      cfg_div = TBL[r][2:1];
      cfg_long_smp = TBL[r][0];
      for (int c = 0; c < 4; c++) vin[c] = level(r, c);
      d = 2 << int'(cfg_div);
      s = cfg_long_smp ? 4 : 2;
      nch = set_last(int'(cfg_chsel)) - set_first(int'(cfg_chsel)) + 1;
      run_conv(0, -1, lat, sh);
      chk("R3 latency", lat, nch * (12 + s) * d);
      chk("R4 sample cycles", sh, nch * s * d);
      chk("R13 busy low at end", busy, 0);
      for (int c = set_first(int'(cfg_chsel)); c <= set_last(int'(cfg_chsel)); c++)
        exp_buf[c] = int'(vin[c]);
      @(negedge clk);
      chk("R11 irq one cycle", irq, 0);
      for (int c = 0; c < 4; c++) begin
        rd_buf(c, v);
        chk("R2 R5 buffer", v, exp_buf[c]);
      end
    end

    // R10: disabled converter ignores a start
    @(negedge clk);
    cfg_chsel = 3'd0; cfg_div = 2'd0; cfg_long_smp = 1'b0; enable = 1'b0;
    sw_start = 1'b1;
    @(negedge clk) sw_start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 start while disabled", busy, 0);
    enable = 1'b1;

    // R10: second start mid-conversion does not restart the sequence
    vin[0] = 10'd345;
    run_conv(0, 10, lat, sh);
    chk("R10 start while busy latency", lat, 28);
    exp_buf[0] = 345;
    rd_buf(0, v);
    chk("R2 buffer ch0", v, 345);

    // R8: timer source, software pulse ignored
    @(negedge clk) cfg_src = 2'd1;
    sw_start = 1'b1;
    @(negedge clk) sw_start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 sw ignored under timer source", busy, 0);
    run_conv(1, -1, lat, sh);
    chk("R8 timer start latency", lat, 28);

    // R9: external falling edge through the synchronizer
    @(negedge clk) cfg_src = 2'd2;
    vin[0] = 10'd600;
    run_conv(2, -1, lat, sh);
    chk("R9 ext start latency", lat, 30);
    rd_buf(0, v);
    chk("R9 buffer after ext start", v, 600);
    exp_buf[0] = 600;
    @(negedge clk) ext_trig_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 rising edge ignored", busy, 0);
    @(negedge clk) cfg_src = 2'd0;
    ext_trig_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R8 ext ignored under sw source", busy, 0);
    ext_trig_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: read and store of channel 2 on the same edge
    @(negedge clk);
    cfg_chsel = 3'd2; vin[2] = 10'd77;
    sw_start = 1'b1;
    @(posedge clk);
    @(negedge clk) sw_start = 1'b0; rd_ch = 2'd2;
    repeat (27) @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R12 read-first old value", int'(rd_data), exp_buf[2]);
    chk("R11 irq at store", irq, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R12 new value next cycle", int'(rd_data), 77);
    exp_buf[2] = 77;

    // R6 continuous scan of channels 0..1, then R7 stop mid-set
    @(negedge clk);
    cfg_chsel = 3'd4; cfg_cont = 1'b1;
    vin[0] = 10'd100; vin[1] = 10'd900;
    run_conv(0, -1, lat, sh);
    chk("R6 first scan", lat, 56);
    cnt = 0; lowcnt = 0;
    while (cnt < 500) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (!busy) lowcnt++;
      if (irq) break;
    end
    chk("R6 repeat interval", cnt, 56);
    chk("R6 busy held", lowcnt, 0);
    enable = 1'b0; vin[0] = 10'd512;
    cnt = 0; irqs = 0;
    while (cnt < 500) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (irq) irqs++;
      if (!busy) break;
    end
    chk("R7 stop after current channel", cnt, 28);
    chk("R7 no irq mid-set", irqs, 0);
    rd_buf(0, v);
    chk("R7 finished channel stored", v, 512);
    rd_buf(1, v);
    chk("R7 later channel untouched", v, 900);
    enable = 1'b1; cfg_cont = 1'b0;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule